// File: doc/BRIEF.md
# Posted Write Acceptance Controller

This block sits on the target side of one port of a two-port bus bridge. For each memory write that arrives on that port, it decides whether to post the write into the bridge's write buffer or to answer it with a target retry. It watches an abstracted address phase (`start_i`) and the data phases that follow it. A write is back-to-back when its address phase falls in the cycle right after the final data phase of the previous transaction, with no idle cycle between them.

Acceptance depends on free buffer space and, for back-to-back writes, on an enable bit. The enable bit comes from a different register for each direction. The block keeps one free-space count for address entries and one for data words. Each push lowers a count and each pop raised by the far side raises it. When the data space runs out in the middle of a burst, the block asserts a disconnect on the last word it accepted. Any data phases that follow are then dropped.

Top module: `posted_wr_accept`

## Requirements
- R1: At an address phase in the idle state, with at least one free address entry, at least one free data word and no back-to-back condition, `accept_o` and `push_addr_o` are high in that same cycle, and `push_addr_val_o` equals `addr_i`.
- R2: An address phase that arrives when the free address count or the free data count is zero is answered with `retry_o` and no `accept_o`. No push strobe fires in any cycle of that transaction, up to and including its final data phase.
- R3: An address phase is back-to-back when the previous cycle carried `data_valid_i` together with `last_i`. A back-to-back write is accepted when space allows and the enable bit for its direction is 1.
- R4: When the selected enable bit is 0, a back-to-back write is retried. `dir_up_i`=1 selects `cmd_b2b_en_i` and `dir_up_i`=0 selects `bctl_b2b_en_i`.
- R5: Each data phase of an accepted write pushes its word in the same cycle: `push_data_o`=1 and `push_data_val_o`=`data_i`.
- R6: Consider a data push that is not the final phase, is not matched by a data pop, and leaves the free data count at zero. That push raises `disconnect_o` in the same cycle. Later data phases of that burst are not pushed.
- R7: The free counts `addr_free_o` and `data_free_o` fall by one after a push and rise by one after a pop. A push and a pop in the same cycle leave the count unchanged.
- R8: Both free counts saturate at their full depth and never go below zero.
- R9: After reset, the free counts equal `ADDR_DEPTH` and `DATA_DEPTH`, all strobes are low, and the first write is not treated as back-to-back.
- R10: More than one posted write can be held at once. A second write is accepted while the first one still occupies the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Address phase of a memory write |
| addr_i | input | ADDR_W | Write address |
| dir_up_i | input | 1 | 1 = upstream write, 0 = downstream write |
| cmd_b2b_en_i | input | 1 | Back-to-back enable for upstream writes |
| bctl_b2b_en_i | input | 1 | Back-to-back enable for downstream writes |
| data_valid_i | input | 1 | Data phase valid |
| last_i | input | 1 | Final data phase of the transaction |
| data_i | input | DATA_W | Write data word |
| pop_addr_i | input | 1 | Far side frees one address entry |
| pop_data_i | input | 1 | Far side frees one data word |
| accept_o | output | 1 | Write posted |
| retry_o | output | 1 | Target retry issued |
| disconnect_o | output | 1 | Disconnect after this accepted word |
| push_addr_o | output | 1 | Address entry push strobe |
| push_addr_val_o | output | ADDR_W | Address being pushed |
| push_data_o | output | 1 | Data word push strobe |
| push_data_val_o | output | DATA_W | Data word being pushed |
| addr_free_o | output | $clog2(ADDR_DEPTH+1) | Free address entries |
| data_free_o | output | $clog2(DATA_DEPTH+1) | Free data words |

## Verification
The case that needs the most care is a data push and a data pop from the far side landing in the same cycle. In that case the free data count must stay where it is. A disconnect must not be raised, even when the count stood at one. The bench provokes this on the final word of a write that arrives just after a pop has reopened a single slot. It then checks that the word is pushed without a disconnect, and that the free data count still reads one afterwards. A second overlap is also exercised: a back-to-back address phase that follows a retried transaction. There, the direction input must pick the right enable bit in the same cycle as the space check.

// File: rtl/pwac_pkg.sv
package pwac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DROP = 2'd2
  } pwac_state_e;
endpackage

// File: rtl/pwac_space_cnt.sv
module pwac_space_cnt #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [CW-1:0] free_o
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0] free_q, free_d;

  always_comb begin
    free_d = free_q;
    if (push_i && !pop_i) begin
      if (free_q != '0) free_d = free_q - 1'b1;
    end else if (pop_i && !push_i) begin
      if (free_q != FULL) free_d = free_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) free_q <= FULL;
    else         free_q <= free_d;
  end

  assign free_o = free_q;

  // R8
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_q <= FULL);

  // R7
  cnt_push_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && free_q != '0) |=> (free_q == $past(free_q) - 1'b1));

  // R7
  cnt_pair_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> $stable(free_q));
endmodule

// File: rtl/pwac_b2b_detect.sv
module pwac_b2b_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_valid_i,
  input  logic last_i,
  input  logic dir_up_i,
  input  logic cmd_b2b_en_i,
  input  logic bctl_b2b_en_i,
  output logic b2b_o,
  output logic b2b_en_o
);
  logic end_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) end_q <= 1'b0;
    else         end_q <= data_valid_i && last_i;
  end

  assign b2b_o    = end_q;
  // each direction takes its enable from a different register
  assign b2b_en_o = dir_up_i ? cmd_b2b_en_i : bctl_b2b_en_i;

  // R3
  b2b_follows_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_valid_i && last_i) |=> b2b_o);
endmodule

// File: rtl/pwac_fsm.sv
module pwac_fsm #(
  parameter int ADDR_DEPTH = 2,
  parameter int DATA_DEPTH = 4,
  localparam int ACW = $clog2(ADDR_DEPTH + 1),
  localparam int DCW = $clog2(DATA_DEPTH + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           data_valid_i,
  input  logic           last_i,
  input  logic           pop_data_i,
  input  logic           b2b_i,
  input  logic           b2b_en_i,
  input  logic [ACW-1:0] addr_free_i,
  input  logic [DCW-1:0] data_free_i,
  output logic           accept_o,
  output logic           retry_o,
  output logic           disconnect_o,
  output logic           push_addr_o,
  output logic           push_data_o,
  output logic           idle_o
);
  import pwac_pkg::*;

  pwac_state_e state_q, state_d;
  logic space_ok, gate_ok, last_slot;

  assign space_ok  = (addr_free_i != '0) && (data_free_i != '0);
  assign gate_ok   = !b2b_i || b2b_en_i;
  assign last_slot = (data_free_i == DCW'(1)) && !pop_data_i;

  always_comb begin
    state_d      = state_q;
    accept_o     = 1'b0;
    retry_o      = 1'b0;
    disconnect_o = 1'b0;
    push_addr_o  = 1'b0;
    push_data_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        if (space_ok && gate_ok) begin
          accept_o    = 1'b1;
          push_addr_o = 1'b1;
          state_d     = ST_XFER;
        end else begin
          retry_o = 1'b1;
          state_d = ST_DROP;
        end
      end
      ST_XFER: if (data_valid_i) begin
        if (data_free_i != '0) begin
          push_data_o = 1'b1;
          if (last_i) state_d = ST_IDLE;
          else if (last_slot) begin
            disconnect_o = 1'b1;
            state_d      = ST_DROP;
          end
        end else begin
          state_d = last_i ? ST_IDLE : ST_DROP;
        end
      end
      ST_DROP: if (data_valid_i && last_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign idle_o = (state_q == ST_IDLE);

  // R2
  accept_retry_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({accept_o, retry_o}));

  // R2
  no_push_on_retry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |=> !push_data_o);

  // R6
  disc_with_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disconnect_o |-> (push_data_o && !last_i));

  // R6
  no_push_after_disc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disconnect_o |=> !push_data_o);
endmodule

// File: rtl/posted_wr_accept.sv
module posted_wr_accept #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int ADDR_DEPTH = 2,
  parameter int DATA_DEPTH = 4,
  localparam int ACW = $clog2(ADDR_DEPTH + 1),
  localparam int DCW = $clog2(DATA_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              dir_up_i,
  input  logic              cmd_b2b_en_i,
  input  logic              bctl_b2b_en_i,
  input  logic              data_valid_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_addr_i,
  input  logic              pop_data_i,
  output logic              accept_o,
  output logic              retry_o,
  output logic              disconnect_o,
  output logic              push_addr_o,
  output logic [ADDR_W-1:0] push_addr_val_o,
  output logic              push_data_o,
  output logic [DATA_W-1:0] push_data_val_o,
  output logic [ACW-1:0]    addr_free_o,
  output logic [DCW-1:0]    data_free_o
);
  logic b2b, b2b_en, idle;

  pwac_b2b_detect u_b2b (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .data_valid_i  (data_valid_i),
    .last_i        (last_i),
    .dir_up_i      (dir_up_i),
    .cmd_b2b_en_i  (cmd_b2b_en_i),
    .bctl_b2b_en_i (bctl_b2b_en_i),
    .b2b_o         (b2b),
    .b2b_en_o      (b2b_en)
  );

  pwac_fsm #(
    .ADDR_DEPTH (ADDR_DEPTH),
    .DATA_DEPTH (DATA_DEPTH)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .data_valid_i (data_valid_i),
    .last_i       (last_i),
    .pop_data_i   (pop_data_i),
    .b2b_i        (b2b),
    .b2b_en_i     (b2b_en),
    .addr_free_i  (addr_free_o),
    .data_free_i  (data_free_o),
    .accept_o     (accept_o),
    .retry_o      (retry_o),
    .disconnect_o (disconnect_o),
    .push_addr_o  (push_addr_o),
    .push_data_o  (push_data_o),
    .idle_o       (idle)
  );

  pwac_space_cnt #(.DEPTH(ADDR_DEPTH)) u_addr_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push_addr_o),
    .pop_i  (pop_addr_i),
    .free_o (addr_free_o)
  );

  pwac_space_cnt #(.DEPTH(DATA_DEPTH)) u_data_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push_data_o),
    .pop_i  (pop_data_i),
    .free_o (data_free_o)
  );

  assign push_addr_val_o = addr_i;
  assign push_data_val_o = data_i;

  // R4
  b2b_disabled_retry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && start_i && b2b && !(dir_up_i ? cmd_b2b_en_i : bctl_b2b_en_i)) |-> retry_o);

  // R2
  full_retry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && start_i && (addr_free_o == '0 || data_free_o == '0)) |-> (retry_o && !push_addr_o));

  // R1
  accept_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> push_addr_o);
endmodule

// File: tb/posted_wr_accept_tb_top.sv
module posted_wr_accept_tb_top;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int NV = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start, dir_up, cmd_en, bctl_en, dv, last, pop_a, pop_d;
  logic [AW-1:0] addr;
  logic [DW-1:0] data;
  logic acc, ret, disc, pa, pd;
  logic [AW-1:0] pa_val;
  logic [DW-1:0] pd_val;
  logic [1:0] afree;
  logic [2:0] dfree;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  posted_wr_accept dut_i (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .addr_i (addr),
    .dir_up_i (dir_up), .cmd_b2b_en_i (cmd_en), .bctl_b2b_en_i (bctl_en),
    .data_valid_i (dv), .last_i (last), .data_i (data),
    .pop_addr_i (pop_a), .pop_data_i (pop_d),
    .accept_o (acc), .retry_o (ret), .disconnect_o (disc),
    .push_addr_o (pa), .push_addr_val_o (pa_val),
    .push_data_o (pd), .push_data_val_o (pd_val),
    .addr_free_o (afree), .data_free_o (dfree)
  );

  // {start,up,cmd_en,bctl_en,dv,last,pop_a,pop_d, acc,ret,push_a,push_d,disc}
  localparam logic [12:0] VEC [NV] = '{
    {8'b0000_0000, 5'b00000}, // 0 idle (R9: no b2b next)
    {8'b1100_0000, 5'b10100}, // 1 R1 accept
    {8'b0000_1000, 5'b00010}, // 2 R5
    {8'b0000_1100, 5'b00010}, // 3 R5 last
    {8'b1101_0000, 5'b01000}, // 4 R4 b2b up, cmd_en=0 -> retry
    {8'b0000_1100, 5'b00000}, // 5 R2 retried data dropped
    {8'b1001_0000, 5'b10100}, // 6 R3 R10 b2b down, bctl_en=1 -> accept
    {8'b0000_1000, 5'b00010}, // 7 R5
    {8'b0000_1000, 5'b00011}, // 8 R6 last slot -> disconnect
    {8'b0000_1100, 5'b00000}, // 9 R6 dropped after disconnect
    {8'b0000_0000, 5'b00000}, // 10 idle
    {8'b1111_0000, 5'b01000}, // 11 R2 no address space
    {8'b0000_1100, 5'b00000}, // 12 R2 dropped
    {8'b0000_0011, 5'b00000}, // 13 R7 pops
    {8'b1100_0000, 5'b10100}, // 14 R1
    {8'b0000_1101, 5'b00010}, // 15 R7 push+pop, no disconnect (R6)
    {8'b0000_0000, 5'b00000}  // 16 idle
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    {start, dir_up, cmd_en, bctl_en, dv, last, pop_a, pop_d} = '0;
    addr = '0;
    data = '0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=5000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_in();
    repeat (3) @(negedge clk);
    #1;
    // R9 reset state
    chk("R9 addr_free", 32'(afree), 32'd2);
    chk("R9 data_free", 32'(dfree), 32'd4);
    chk("R9 strobes", 32'({acc, ret, disc, pa, pd}), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {start, dir_up, cmd_en, bctl_en, dv, last, pop_a, pop_d} = VEC[i][12:5];
      addr = AW'(i * 16);
      data = DW'(i + 100);
      #1;
      chk($sformatf("R1 R2 R3 R4 R5 R6 R10 row %0d", i),
          32'({acc, ret, pa, pd, disc}), 32'(VEC[i][4:0]));
      if (VEC[i][2]) chk($sformatf("R1 addr row %0d", i), pa_val, 32'(i * 16));
      if (VEC[i][1]) chk($sformatf("R5 data row %0d", i), pd_val, 32'(i + 100));
    end

    @(negedge clk);
    idle_in();
    #1;
    // R7 counts after table: push+pop left data at 1
    chk("R7 addr_free", 32'(afree), 32'd0);
    chk("R7 data_free", 32'(dfree), 32'd1);

    // R8 saturation at full depth
    pop_a = 1'b1;
    pop_d = 1'b1;
    repeat (6) @(negedge clk);
    idle_in();
    #1;
    chk("R8 addr sat", 32'(afree), 32'd2);
    chk("R8 data sat", 32'(dfree), 32'd4);

    // R9 reset mid-run clears b2b history and counts
    start = 1'b1;
    dir_up = 1'b1;
    @(negedge clk);
    idle_in();
    dv = 1'b1;
    last = 1'b1;
    @(negedge clk);
    idle_in();
    rst_n = 1'b0;
    #1;
    chk("R9 reset addr_free", 32'(afree), 32'd2);
    chk("R9 reset data_free", 32'(dfree), 32'd4);
    @(negedge clk);
    rst_n = 1'b1;
    start = 1'b1;
    dir_up = 1'b1;
    #1;
    // first write after reset: not back-to-back, accepted with enables low
    chk("R9 first accept", 32'({acc, ret}), 32'b10);
    @(negedge clk);
    idle_in();
    dv = 1'b1;
    last = 1'b1;
    @(negedge clk);
    idle_in();
    start = 1'b1;
    dir_up = 1'b0;
    cmd_en = 1'b1;
    bctl_en = 1'b0;
    #1;
    // R4 downstream uses bctl enable even when cmd enable is set
    chk("R4 down uses bctl", 32'({acc, ret}), 32'b01);
    @(negedge clk);
    idle_in();
    dv = 1'b1;
    last = 1'b1;
    #1;
    chk("R2 no push on retried", 32'(pd), 32'd0);
    @(negedge clk);
    idle_in();
    #1;
    // R7 only one data push since reset
    chk("R7 data_free after one push", 32'(dfree), 32'd3);
    chk("R7 addr_free after one push", 32'(afree), 32'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule